// File: doc/BRIEF.md
# Twelve-Channel Reloading Divider Bank

This block turns one fast clock into twelve square waves, one for each semitone of an octave. Every channel owns a 9-bit down counter and a toggle flip-flop. The counter is preset to one less than that channel's divisor N. When it reaches zero, an all-zero test fires. The counter then takes its reload value again and the channel's output flips. The toggle halves the rate, so the block is clocked at twice the wanted master rate, and each output is an exact 50% duty square wave at clock/(2·N).

Each channel has a divisor register. After reset these registers hold a built-in tuning, set by a parameter. A single parallel load strobe replaces all twelve divisors at once. A new divisor takes effect at each channel's next reload, so the half period in progress is never cut short. An enable input freezes every counter and output while it is low.

Top module: `tone_divider_bank`

## Requirements
- R1: With `en` high and a channel's divisor N in 1..511, that channel's output is a square wave. It stays high for N clocks and low for N clocks, so its period is 2·N clocks.
- R2: The default divisors for channels 0 to 11 are 239, 253, 268, 284, 301, 319, 338, 358, 379, 402, 426 and 451. Channel k sits at bits [9k+8:9k] of `ld_div` and at bit k of `tone_o`. After reset, channel k first flips at its N-th enabled clock edge.
- R3: While `rst` is high at a rising edge, every output clears to 0, every divisor returns to its default, and every counter is preset from that default.
- R4: While `en` is low, no output and no counter changes. Counting resumes from the held state once `en` returns high.
- R5: When `ld` is high at an edge, all twelve divisors are captured from `ld_div`, whether `en` is high or low. A channel keeps its current count and uses the new divisor from its next reload on. A reload at the same edge as the load still uses the old divisor.
- R6: A divisor of 0 acts as 1, so that channel flips on every enabled edge.
- R7: The largest divisor, 511, gives an output period of 1022 clocks.
- R8: Channels run independently: each one follows only its own divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, at twice the master tone rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; low freezes all channels |
| ld | input | 1 | Strobe that captures all divisors from `ld_div` |
| ld_div | input | 108 | Twelve 9-bit divisors, channel k at bits [9k+8:9k] |
| tone_o | output | 12 | Registered square-wave outputs, channel k at bit k |

## Verification
The assertions assume that `en`, `ld` and `ld_div` are settled before each rising edge. They also assume that a divisor's meaning depends only on the value held when a reload happens. For that reason the load checks compare the captured value with the value present one edge earlier, not with any later value. The stimulus changes every input only on falling edges. It also issues loads both while channels are counting and while they are frozen, so each case of capture and reload timing comes up without breaking those assumptions.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
  localparam int unsigned CH_COUNT = 12;
  localparam int unsigned CNT_BITS = 9;

  // Channel 0 in the least significant slice
  localparam logic [CH_COUNT*CNT_BITS-1:0] DEFAULT_DIVS = {
    9'd451, 9'd426, 9'd402, 9'd379, 9'd358, 9'd338,
    9'd319, 9'd301, 9'd284, 9'd268, 9'd253, 9'd239
  };
endpackage

// File: rtl/tdb_div_store.sv
module tdb_div_store #(
  parameter int unsigned NUM_CH = 12,
  parameter int unsigned CNT_W  = 9,
  parameter logic [NUM_CH*CNT_W-1:0] DIV_INIT = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld,
  input  logic [NUM_CH*CNT_W-1:0] ld_div,
  output logic [NUM_CH*CNT_W-1:0] rel_o
);
  logic [CNT_W-1:0] div_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_CH; k++) div_q[k] <= DIV_INIT[k*CNT_W +: CNT_W];
    end else if (ld) begin
      for (int k = 0; k < NUM_CH; k++) div_q[k] <= ld_div[k*CNT_W +: CNT_W];
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_rel
    // zero divisor is treated as one: reload value 0
    assign rel_o[k*CNT_W +: CNT_W] =
      (div_q[k] == '0) ? '0 : div_q[k] - CNT_W'(1);

    // R5
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
      ld |=> div_q[k] == $past(ld_div[k*CNT_W +: CNT_W]));
    // R5
    load_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(div_q[k]));
  end
endmodule

// File: rtl/tdb_channel.sv
module tdb_channel #(
  parameter int unsigned CNT_W = 9,
  parameter logic [CNT_W-1:0] RST_REL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] rel_i,
  output logic             tone_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tone_q;
  logic             at_zero;

  assign at_zero = ~|cnt_q;
  assign tone_o  = tone_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= RST_REL;
      tone_q <= 1'b0;
    end else if (en) begin
      if (at_zero) begin
        cnt_q  <= rel_i;
        tone_q <= ~tone_q;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !tone_q);
  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt_q) && $stable(tone_q));
  // R1
  toggle_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_q == '0) |=> tone_q != $past(tone_q));
  // R1
  quiet_between_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_q != '0) |=> $stable(tone_q) && cnt_q == $past(cnt_q) - CNT_W'(1));
  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_q == '0) |=> cnt_q == $past(rel_i));
endmodule

// File: rtl/tone_divider_bank.sv
module tone_divider_bank #(
  parameter int unsigned NUM_CH = tdb_pkg::CH_COUNT,
  parameter int unsigned CNT_W  = tdb_pkg::CNT_BITS,
  parameter logic [NUM_CH*CNT_W-1:0] DIV_INIT = tdb_pkg::DEFAULT_DIVS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    ld,
  input  logic [NUM_CH*CNT_W-1:0] ld_div,
  output logic [NUM_CH-1:0]       tone_o
);
  logic [NUM_CH*CNT_W-1:0] rel;

  tdb_div_store #(
    .NUM_CH  (NUM_CH),
    .CNT_W   (CNT_W),
    .DIV_INIT(DIV_INIT)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .ld    (ld),
    .ld_div(ld_div),
    .rel_o (rel)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [CNT_W-1:0] INIT_D = DIV_INIT[k*CNT_W +: CNT_W];
    localparam logic [CNT_W-1:0] INIT_R = (INIT_D == '0) ? '0 : INIT_D - CNT_W'(1);

    tdb_channel #(
      .CNT_W  (CNT_W),
      .RST_REL(INIT_R)
    ) u_ch (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .rel_i (rel[k*CNT_W +: CNT_W]),
      .tone_o(tone_o[k])
    );
  end
endmodule

// File: tb/tone_divider_bank_bench.sv
`timescale 1ns/1ps
module tone_divider_bank_bench;
  localparam int NC = 12;
  localparam int W  = 9;

  logic              clk = 1'b0;
  logic              rst = 1'b0;
  logic              en  = 1'b0;
  logic              ld  = 1'b0;
  logic [NC*W-1:0]   ld_div = '0;
  logic [NC-1:0]     tone_o;

  int vectors = 0;
  int miscompares = 0;
  bit armed = 1'b0;
  bit done = 1'b0;
  string phase = "R3 reset";

  int defaults [NC] = '{239, 253, 268, 284, 301, 319, 338, 358, 379, 402, 426, 451};
  int left_m [NC];
  int div_m  [NC];
  bit [NC-1:0] tone_m;

  always #2.5 clk = ~clk;

  tone_divider_bank u_tone_divider_bank (
    .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_div(ld_div), .tone_o(tone_o)
  );

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  // behavioural reference: edges remaining until each flip
  always @(posedge clk) begin
    if (rst) begin
      armed = 1'b1;
      for (int k = 0; k < NC; k++) begin
        div_m[k]  = defaults[k];
        left_m[k] = eff(defaults[k]);
      end
      tone_m = '0;
    end else if (armed) begin
      if (en) begin
        for (int k = 0; k < NC; k++) begin
          left_m[k] = left_m[k] - 1;
          if (left_m[k] == 0) begin
            tone_m[k] = ~tone_m[k];
            left_m[k] = eff(div_m[k]);
          end
        end
      end
      if (ld) begin
        for (int k = 0; k < NC; k++) div_m[k] = int'(ld_div[k*W +: W]);
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      vectors++;
      if (tone_o !== tone_m) begin
        miscompares++;
        $display("FAIL %s: tone_o=%h expected %h at %0t", phase, tone_o, tone_m, $time);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_divs(input int v [NC]);
    for (int k = 0; k < NC; k++) ld_div[k*W +: W] = W'(v[k]);
  endtask

  task automatic explicit_check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp_v);
    vectors++;
    if (act !== exp_v) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp_v);
    end
  endtask

  initial begin
    int set_a [NC] = '{0, 1, 2, 511, 3, 7, 100, 239, 0, 64, 5, 300};
    int set_b [NC] = '{4, 0, 9, 1, 13, 2, 50, 0, 6, 511, 3, 8};
    logic [15:0] lfsr = 16'hACE1;
    bit [NC-1:0] frozen;

    @(negedge clk);
    rst = 1'b1;
    cycles(3);
    explicit_check("R3 outputs cleared in reset", tone_o, '0);
    rst = 1'b0;

    phase = "R1 R2 R8 default tuning";
    en = 1'b1;
    cycles(238);
    explicit_check("R2 channel 0 not yet flipped after 238 edges", tone_o, '0);
    cycles(1);
    explicit_check("R2 channel 0 flips at edge 239", tone_o, 12'h001);
    cycles(1200);

    phase = "R4 enable low";
    en = 1'b0;
    cycles(1);
    frozen = tone_o;
    cycles(60);
    explicit_check("R4 outputs frozen while disabled", tone_o, frozen);
    phase = "R4 resume";
    en = 1'b1;
    cycles(500);

    phase = "R5 R6 R7 load while running";
    set_divs(set_a);
    ld = 1'b1;
    cycles(1);
    ld = 1'b0;
    ld_div = '0;
    cycles(2600);

    phase = "R5 load while disabled";
    en = 1'b0;
    set_divs(set_b);
    ld = 1'b1;
    cycles(1);
    ld = 1'b0;
    cycles(20);
    en = 1'b1;
    phase = "R5 R6 R7 second divisor set";
    cycles(2200);

    phase = "R3 reset restores defaults";
    rst = 1'b1;
    cycles(2);
    explicit_check("R3 outputs cleared after reset with loaded divisors", tone_o, '0);
    rst = 1'b0;
    phase = "R2 R3 defaults after second reset";
    cycles(700);

    phase = "R4 R5 irregular enable and loads";
    for (int i = 0; i < 2500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      en = lfsr[0] | lfsr[3];
      ld = (i % 700) == 350;
      if (ld) set_divs((i < 1000) ? set_a : set_b);
      cycles(1);
    end
    ld = 1'b0;
    en = 1'b1;
    cycles(50);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule